// File: doc/BRIEF.md
# Nonlinear-Segment Carry-Select Adder

A purely combinational adder that sums two 64-bit operands and an incoming carry. The result is a 64-bit sum and an outgoing carry. The operand is cut into segments whose widths grow from the least significant end. Inside every segment except the lowest, two ripple-carry chains run side by side. One chain assumes the carry entering the segment is 0 and the other assumes it is 1.

When the real carry from the segment below arrives, it picks one of the two finished results and forwards the matching carry upward. The lowest segment has a single chain driven by the real carry-in. The critical path is the lowest segment's ripple plus one selection per higher segment. Wider segments sit higher, so their longer ripple finishes about when their select carry arrives.

The segment widths form a parameter array. Their total is checked against the operand width when the design is elaborated. Registers, subtraction and overflow flags are not part of this block.

Top module: `csel_adder`

## Requirements
- R1: For any operands and carry-in, {cout_o, sum_o} equals the arithmetic value a_i + b_i + cin_i, taken as a 65-bit unsigned number.
- R2: With the default widths, segments cover bits [3:0], [7:4], [12:8], [18:13], [25:19], [33:26], [42:34], [52:43] and [63:53]. A carry that ripples out of the top bit of any segment enters the next segment's lowest bit. For a_i = 2^L - 1, b_i = 0 and cin_i = 1, where L is a segment's lowest bit, the sum is exactly 2^L.
- R3: The carry leaving a segment is 1 when the segment generates a carry on its own, whatever its incoming carry. A carry generated at the top bit of one segment must appear at the lowest bit of the next segment when cin_i = 0.
- R4: When every bit position propagates (a_i XOR b_i all ones) and cin_i = 1, the carry crosses all nine segments: sum_o is 0 and cout_o is 1.
- R5: With both operands zero, sum_o equals cin_i (zero-extended) and cout_o is 0.
- R6: The outputs depend only on the present inputs, with no storage. A new input pattern is reflected at the outputs within the same clock period in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Incoming carry into bit 0 |
| sum_o | output | 64 | Sum bits |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
The two functions that can coincide are a segment producing its own carry and the same segment passing on a selected carry from below, possibly in the very next select stage. Operands placed at each segment boundary, with bits generating just under the boundary and propagating above it, force both at once. Long all-propagate patterns and many random operands with random carry-in stress both functions across every boundary. Every outcome is judged against the 65-bit arithmetic sum computed in the bench.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int W    = 64,
  parameter int NSEG = 9,
  parameter int SEG_W [NSEG] = '{4, 4, 5, 6, 7, 8, 9, 10, 11}
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  function automatic int seg_lo(input int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += SEG_W[k];
    return acc;
  endfunction

  localparam int TOTAL = seg_lo(NSEG);

  if (TOTAL != W) begin : g_bad_widths
    $error("segment widths do not add up to the operand width");
  end

  logic [W-1:0] prop, gen;
  logic [NSEG:0] segc;

  assign prop    = a_i ^ b_i;
  assign gen     = a_i & b_i;
  assign segc[0] = cin_i;
  assign cout_o  = segc[NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = seg_lo(s);
    localparam int N  = SEG_W[s];

    logic [N:0]   c0;
    logic [N-1:0] s0;

    if (s == 0) begin : g_single
      assign c0[0] = segc[0];
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign s0[i]   = prop[LO+i] ^ c0[i];
        assign c0[i+1] = gen[LO+i] | (prop[LO+i] & c0[i]);
      end
      assign sum_o[LO +: N] = s0;
      assign segc[1]        = c0[N];
    end else begin : g_pair
      logic [N:0]   c1;
      logic [N-1:0] s1;
      assign c0[0] = 1'b0;
      assign c1[0] = 1'b1;
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign s0[i]   = prop[LO+i] ^ c0[i];
        assign s1[i]   = prop[LO+i] ^ c1[i];
        assign c0[i+1] = gen[LO+i] | (prop[LO+i] & c0[i]);
        assign c1[i+1] = gen[LO+i] | (prop[LO+i] & c1[i]);
      end
      assign sum_o[LO +: N] = segc[s] ? s1 : s0;
      assign segc[s+1]      = c0[N] | (c1[N] & segc[s]);
    end
  end

endmodule

module csel_adder_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o
);

  logic [W:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      // R1
      sum_match_chk: assert ({cout_o, sum_o} == ref_total)
        else $error("sum mismatch");
      // R5
      if (a_i == '0 && b_i == '0)
        zero_pass_chk: assert (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o)
          else $error("zero operand result wrong");
      // R4
      if ((a_i ^ b_i) == '1 && cin_i)
        full_prop_chk: assert (sum_o == '0 && cout_o)
          else $error("full propagate result wrong");
      // R3
      if (a_i[W-1] && b_i[W-1])
        top_gen_chk: assert (cout_o)
          else $error("generated top carry lost");
      // R6
      known_out_chk: assert (!$isunknown({sum_o, cout_o}))
        else $error("unknown output");
    end
  end

endmodule

bind csel_adder csel_adder_chk #(.W(W)) u_csel_adder_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/test_csel_adder.sv
module test_csel_adder;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csel_adder i_csel_adder (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout));

  task automatic apply_check(input string tag, input logic [W-1:0] ta,
                             input logic [W-1:0] tb, input logic tc);
    logic [W:0] exp;
    @(posedge clk);
    #1;
    a = ta; b = tb; cin = tc;
    exp = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
    @(negedge clk);
    n_checks++;
    if ({cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, {cout, sum}, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lows [8] = '{4, 8, 13, 19, 26, 34, 43, 53};
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    // reset-phase output with zero inputs (R5)
    @(negedge clk);
    n_checks++;
    if ({cout, sum} !== '0) begin
      n_fail++;
      $display("FAIL R5 reset: got %h expected 0", {cout, sum});
    end
    rst = 1'b0;

    apply_check("R5 zero cin1", '0, '0, 1'b1);
    apply_check("R5 zero cin0", '0, '0, 1'b0);
    apply_check("R4 all ones plus cin", '1, '0, 1'b1);
    apply_check("R4 alternating", {32{2'b01}}, {32{2'b10}}, 1'b1);
    apply_check("R1 max plus max", '1, '1, 1'b1);

    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] m;
      m = (64'd1 << lows[k]) - 64'd1;
      apply_check("R2 ripple to boundary", m, '0, 1'b1);
      apply_check("R3 generate at boundary", 64'd1 << (lows[k]-1), 64'd1 << (lows[k]-1), 1'b0);
      // generated below boundary, propagated through the whole next segment
      apply_check("R3 generate then propagate", (64'd1 << (lows[k]-1)) | ~m, 64'd1 << (lows[k]-1), 1'b0);
    end

    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k % 4 == 1) rb = ~ra;
      apply_check("R1 random", ra, rb, 1'($urandom));
    end

    // R6: back-to-back changes, each checked in its own period
    apply_check("R6 change one", 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b1);
    apply_check("R6 change two", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule